// File: doc/BRIEF.md
# Holdover History Tracker

This block maintains the frequency offset that a clock synthesizer falls back on when it goes into holdover. It takes a long-term filtered offset estimate from an upstream filter, which is not part of this block. It copies that estimate into a holdover register only after the loop has stayed synchronized for a settling period. The length of that period follows the bandwidth setting of the long-term filter. Once copying has begun, the register follows the estimate on every clock until a disturbing event occurs. Then it freezes at the last value it took.

A settling counter advances on one-second ticks while the loop stays synchronized. The counter restarts whenever updating stops or synchronization is lost. Two status bits are exported. The tracking bit shows that the register is being refreshed right now. The availability bit shows that the register holds a learned value, and it only reads 1 while the usage select picks the device history. A flush command takes one data bit. A 0 only halts tracking. A 1 discards the learned value and reloads the calibrated free-running offset.

Top module: `hold_hist_track`

## Requirements
- R1: After reset, `hold_val` equals the parameter `FREERUN_OFS`, and `dht` and `hha` are 0.
- R2: For bandwidth codes 0 to 7, the settling time is 2^(code+1) ticks: code 0 (1.3 Hz) needs 2 ticks, code 1 needs 4 ticks, and code 7 needs 256 ticks. `dht` rises in the cycle after the clock edge that samples the final tick.
- R3: Bandwidth codes 8 to 15 (the narrowest filters) all use a settling time of 256 ticks.
- R4: While `dht` is 1 and no stop condition is present, `hold_val` after each clock edge equals the `lt_hist` value sampled at that edge.
- R5: Each of the following is a stop condition: `ref_switch`, `los`, `lol`, `in_freerun` or `in_holdover` high, `locked` low, or a flush write (`flush_we` high) with `flush_bit` 0. A stop condition clears `dht` at the next edge and leaves `hold_val` unchanged.
- R6: `hha` is 1 exactly when a value has been learned since the last reset or value-flush and `use_dev_hist` is 1. A stop that is not a value-flush leaves `hha` at 1.
- R7: After a stop, updating resumes only after the full settling time has again been counted.
- R8: A flush write with `flush_bit` 1 loads `FREERUN_OFS` into `hold_val` and clears `dht` and `hha` at the next edge.
- R9: A stop condition in the same cycle as the final settling tick prevents tracking from starting, and counting restarts from zero.
- R10: Ticks count only while `locked` is 1 and no stop is present. Any interruption restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lt_hist | input | HIST_W | Long-term filtered offset estimate |
| locked | input | 1 | Loop synchronized to the selected reference |
| ref_switch | input | 1 | Reference switch event |
| los | input | 1 | Loss-of-signal event |
| lol | input | 1 | Loss-of-lock event |
| in_freerun | input | 1 | Device is in free-run mode |
| in_holdover | input | 1 | Device is in holdover mode |
| flush_we | input | 1 | Flush command strobe |
| flush_bit | input | 1 | Flush data: 0 halts tracking, 1 also discards the value |
| bw_code | input | 4 | Long-term filter bandwidth code |
| tick_1s | input | 1 | One-second tick pulse |
| use_dev_hist | input | 1 | Usage select: device history chosen |
| hold_val | output | HIST_W | Holdover offset register |
| dht | output | 1 | Tracking: register being refreshed |
| hha | output | 1 | Holdover value available |

## Verification
The bench drives the exact tick count at each settling boundary: 2, 4 and 256 ticks, including the saturated codes. A counter that is off by one would raise `dht` a tick early or late, and a missing saturation would wait far beyond 256 ticks. Each stop source is applied on its own while tracking runs. This exposes a register that keeps copying for one more cycle, or an `hha` that drops when it should hold. A stop that lands on the final tick, and a lock loss part-way through counting, catch timers that fire anyway or resume from a stale count. The two flush values are applied separately to catch designs that confuse a tracking halt with a value discard.

// File: rtl/hht_pkg.sv
package hht_pkg;

    localparam int BW_W = 4;

    typedef logic [BW_W-1:0] bw_code_t;

    // Decoded stop causes for one cycle.
    typedef struct packed {
        logic halt;     // any condition that ends or blocks tracking
        logic discard;  // value flush: reload the free-running offset
    } stop_t;

    // Settling length in ticks: doubles per code step, saturates at 2^max_exp.
    function automatic int unsigned settle_len(input bw_code_t code, input int unsigned max_exp);
        int unsigned e;
        e = int'(code) + 1;
        if (e > max_exp) e = max_exp;
        return 32'd1 << e;
    endfunction

endpackage

// File: rtl/hht_stop_decode.sv
module hht_stop_decode (
    input  logic            ref_switch,
    input  logic            los,
    input  logic            lol,
    input  logic            in_freerun,
    input  logic            in_holdover,
    input  logic            locked,
    input  logic            flush_we,
    input  logic            flush_bit,
    output hht_pkg::stop_t  stop
);
    always_comb begin
        stop.discard = flush_we & flush_bit;
        stop.halt    = ref_switch | los | lol | in_freerun | in_holdover
                     | ~locked | flush_we;
    end
endmodule

// File: rtl/hht_settle_timer.sv
module hht_settle_timer #(
    parameter int unsigned MAX_EXP = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              run,
    input  logic              tick,
    input  hht_pkg::bw_code_t bw_code,
    output logic              expire
);
    localparam int CNT_W = MAX_EXP + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit  = CNT_W'(hht_pkg::settle_len(bw_code, MAX_EXP) - 1);
    assign expire = run & tick & ~clear & (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || clear || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= expire ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hht_track_ctrl.sv
module hht_track_ctrl (
    input  logic           clk,
    input  logic           rst,
    input  hht_pkg::stop_t stop,
    input  logic           expire,
    output logic           tracking,
    output logic           avail
);
    always_ff @(posedge clk) begin
        if (rst || stop.halt) begin
            tracking <= 1'b0;
        end else if (expire) begin
            tracking <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || stop.discard) begin
            avail <= 1'b0;
        end else if (expire && !stop.halt) begin
            avail <= 1'b1;
        end
    end
endmodule

// File: rtl/hht_value_reg.sv
module hht_value_reg #(
    parameter int                 HIST_W      = 24,
    parameter logic [HIST_W-1:0]  FREERUN_OFS = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  hht_pkg::stop_t    stop,
    input  logic              tracking,
    input  logic [HIST_W-1:0] lt_hist,
    output logic [HIST_W-1:0] hold_val
);
    always_ff @(posedge clk) begin
        if (rst || stop.discard) begin
            hold_val <= FREERUN_OFS;
        end else if (tracking && !stop.halt) begin
            hold_val <= lt_hist;
        end
    end
endmodule

// File: rtl/hold_hist_track.sv
module hold_hist_track #(
    parameter int                 HIST_W      = 24,
    parameter int unsigned        MAX_EXP     = 8,
    parameter logic [HIST_W-1:0]  FREERUN_OFS = 24'h001A2B
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [HIST_W-1:0]        lt_hist,
    input  logic                     locked,
    input  logic                     ref_switch,
    input  logic                     los,
    input  logic                     lol,
    input  logic                     in_freerun,
    input  logic                     in_holdover,
    input  logic                     flush_we,
    input  logic                     flush_bit,
    input  logic [hht_pkg::BW_W-1:0] bw_code,
    input  logic                     tick_1s,
    input  logic                     use_dev_hist,
    output logic [HIST_W-1:0]        hold_val,
    output logic                     dht,
    output logic                     hha
);
    hht_pkg::stop_t stop;
    logic           expire;
    logic           tracking;
    logic           avail;

    hht_stop_decode u_dec (
        .ref_switch (ref_switch),
        .los        (los),
        .lol        (lol),
        .in_freerun (in_freerun),
        .in_holdover(in_holdover),
        .locked     (locked),
        .flush_we   (flush_we),
        .flush_bit  (flush_bit),
        .stop       (stop)
    );

    hht_settle_timer #(.MAX_EXP(MAX_EXP)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .clear  (stop.halt),
        .run    (~tracking),
        .tick   (tick_1s),
        .bw_code(bw_code),
        .expire (expire)
    );

    hht_track_ctrl u_ctl (
        .clk     (clk),
        .rst     (rst),
        .stop    (stop),
        .expire  (expire),
        .tracking(tracking),
        .avail   (avail)
    );

    hht_value_reg #(.HIST_W(HIST_W), .FREERUN_OFS(FREERUN_OFS)) u_val (
        .clk     (clk),
        .rst     (rst),
        .stop    (stop),
        .tracking(tracking),
        .lt_hist (lt_hist),
        .hold_val(hold_val)
    );

    assign dht = tracking;
    assign hha = avail & use_dev_hist;
endmodule

// File: rtl/hht_chk.sv
module hht_chk #(
    parameter int                HIST_W      = 24,
    parameter logic [HIST_W-1:0] FREERUN_OFS = '0
) (
    input logic              clk,
    input logic              rst,
    input logic [HIST_W-1:0] lt_hist,
    input logic              locked,
    input logic              ref_switch,
    input logic              los,
    input logic              lol,
    input logic              in_freerun,
    input logic              in_holdover,
    input logic              flush_we,
    input logic              flush_bit,
    input logic              tick_1s,
    input logic              use_dev_hist,
    input logic [HIST_W-1:0] hold_val,
    input logic              dht,
    input logic              hha
);
    logic any_stop;
    logic wipe;
    assign any_stop = ref_switch | los | lol | in_freerun | in_holdover | ~locked | flush_we;
    assign wipe     = flush_we & flush_bit;

    assert_follow_R4: assert property (@(posedge clk) disable iff (rst)
        dht && !any_stop |=> hold_val == $past(lt_hist));

    // Also covers R9: a stop never lets tracking be on after the edge.
    assert_freeze_R5: assert property (@(posedge clk) disable iff (rst)
        any_stop && !wipe |=> !dht && $stable(hold_val));

    assert_avail_keep_R6: assert property (@(posedge clk) disable iff (rst)
        hha && !wipe |=> hha || !use_dev_hist);

    assert_avail_on_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(dht) && use_dev_hist |-> hha);

    assert_start_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(dht) |-> $past(tick_1s) && $past(locked));

    assert_wipe_R8: assert property (@(posedge clk) disable iff (rst)
        wipe |=> !dht && !hha && hold_val == FREERUN_OFS);
endmodule

bind hold_hist_track hht_chk #(.HIST_W(HIST_W), .FREERUN_OFS(FREERUN_OFS)) u_chk (
    .clk(clk), .rst(rst), .lt_hist(lt_hist), .locked(locked),
    .ref_switch(ref_switch), .los(los), .lol(lol), .in_freerun(in_freerun),
    .in_holdover(in_holdover), .flush_we(flush_we), .flush_bit(flush_bit),
    .tick_1s(tick_1s), .use_dev_hist(use_dev_hist), .hold_val(hold_val),
    .dht(dht), .hha(hha)
);

// File: tb/sim_hold_hist_track.sv
`timescale 1ns/1ps
module sim_hold_hist_track;
    localparam logic [23:0] FREE = 24'h001A2B;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] lt_hist = 24'h100000;
    logic        locked = 1'b0, ref_switch = 1'b0, los = 1'b0, lol = 1'b0;
    logic        in_freerun = 1'b0, in_holdover = 1'b0;
    logic        flush_we = 1'b0, flush_bit = 1'b0;
    logic [3:0]  bw_code = 4'd0;
    logic        tick_1s = 1'b0, use_dev_hist = 1'b0;
    logic [23:0] hold_val;
    logic        dht, hha;

    always #4 clk = ~clk;

    hold_hist_track u0 (
        .clk(clk), .rst(rst), .lt_hist(lt_hist), .locked(locked),
        .ref_switch(ref_switch), .los(los), .lol(lol), .in_freerun(in_freerun),
        .in_holdover(in_holdover), .flush_we(flush_we), .flush_bit(flush_bit),
        .bw_code(bw_code), .tick_1s(tick_1s), .use_dev_hist(use_dev_hist),
        .hold_val(hold_val), .dht(dht), .hha(hha)
    );

    typedef struct {
        logic [23:0] hold;
        logic        dht;
        logic        hha;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 0;

    // Reference state derived from the requirements.
    logic [23:0] m_hold = FREE;
    logic        m_trk = 0, m_av = 0;
    int          m_cnt = 0;
    string       cur = "R1";

    function automatic int settle_of(input logic [3:0] c);
        return (c >= 4'd7) ? 256 : (2 << c);
    endfunction

    task automatic cyc();
        exp_t e;
        logic stp, wipe;
        lt_hist = lt_hist + 24'h013579;
        stp  = ref_switch | los | lol | in_freerun | in_holdover | !locked | flush_we;
        wipe = flush_we & flush_bit;
        if (wipe) begin
            m_hold = FREE; m_trk = 0; m_av = 0; m_cnt = 0;
        end else if (stp) begin
            m_trk = 0; m_cnt = 0;
        end else if (m_trk) begin
            m_hold = lt_hist;
        end else if (tick_1s) begin
            if (m_cnt >= settle_of(bw_code) - 1) begin
                m_trk = 1; m_av = 1; m_cnt = 0;
            end else begin
                m_cnt++;
            end
        end
        e.hold = m_hold; e.dht = m_trk; e.hha = m_av & use_dev_hist; e.tag = cur;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            tick_1s = 1'b1; cyc(); tick_1s = 1'b0;
            for (int g = 0; g < gap; g++) cyc();
        end
    endtask

    // Monitor: compares each result one step after the edge that made it.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk); #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                n_vec++;
                if (hold_val !== e.hold || dht !== e.dht || hha !== e.hha) begin
                    n_bad++;
                    $display("FAIL %s: hold=%h dht=%b hha=%b expected hold=%h dht=%b hha=%b",
                             e.tag, hold_val, dht, hha, e.hold, e.dht, e.hha);
                end
            end
        end
    end

    initial begin
        #1600000;
        if (!done) begin
            done = 1; n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        n_vec++;
        if (hold_val !== FREE || dht !== 1'b0 || hha !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: hold=%h dht=%b hha=%b expected hold=%h dht=0 hha=0",
                     hold_val, dht, hha, FREE);
        end

        // R2 / R4 / R6: shortest settle, then tracking follows the input
        cur = "R2"; locked = 1; use_dev_hist = 1; bw_code = 0;
        cyc(); ticks(2, 0);
        cur = "R4"; repeat (5) cyc(); tick_1s = 1; cyc(); tick_1s = 0;

        // R5 / R6: every stop source freezes the value, availability stays
        for (int k = 0; k < 7; k++) begin
            cur = "R5";
            case (k)
                0: los = 1;
                1: lol = 1;
                2: ref_switch = 1;
                3: in_freerun = 1;
                4: in_holdover = 1;
                5: locked = 0;
                default: begin flush_we = 1; flush_bit = 0; end
            endcase
            cyc();
            los = 0; lol = 0; ref_switch = 0; in_freerun = 0; in_holdover = 0;
            locked = 1; flush_we = 0;
            cur = "R6"; repeat (3) cyc();
            cur = "R7"; ticks(2, 1);
            cyc();
        end

        // R10 / R7: code 1, lock drop mid-count restarts from zero
        cur = "R10"; los = 1; cyc(); los = 0; bw_code = 1;
        ticks(3, 1);
        locked = 0; tick_1s = 1; cyc(); tick_1s = 0; locked = 1;
        ticks(3, 2);
        cur = "R7"; ticks(1, 0); repeat (3) cyc();

        // R6: usage select gates availability
        cur = "R6"; use_dev_hist = 0; repeat (2) cyc(); use_dev_hist = 1; cyc();

        // R8: value flush while tracking
        cur = "R8"; flush_we = 1; flush_bit = 1; cyc(); flush_we = 0; flush_bit = 0;
        repeat (2) cyc();

        // R9: stop on the final tick blocks tracking
        cur = "R9"; bw_code = 0;
        ticks(1, 0);
        ref_switch = 1; tick_1s = 1; cyc(); ref_switch = 0; tick_1s = 0;
        ticks(1, 1); ticks(1, 1);

        // R2: code 7 needs 256 ticks
        cur = "R2"; lol = 1; cyc(); lol = 0; bw_code = 7;
        ticks(256, 0); cyc();

        // R3: narrow codes saturate at 256 ticks
        cur = "R3"; lol = 1; cyc(); lol = 0; bw_code = 9;
        ticks(256, 0); cyc();
        lol = 1; cyc(); lol = 0; bw_code = 15;
        ticks(255, 0); cyc(); ticks(1, 0); cyc();

        @(posedge clk); #3;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule